// File: doc/BRIEF.md
# Write Lane Mirroring Stage

This stage sits on the write path of a bridge that masters a 32-bit bus on which some targets have no byte-enable inputs. Each request carries a two-bit byte offset, a two-bit transfer size and a word of write data whose bytes already sit in their natural lanes. The stage works out which lanes the transfer covers and emits the matching byte-enable vector. It also copies the addressed bytes down into the low-numbered lanes, because a narrow target that ignores enables always samples those lanes.

Targets that honour byte enables take only the enabled lanes and never see the copies. Lanes that are neither enabled nor mirrored are driven to zero, so the output word is fully determined by the request. A request whose offset and size would run past the end of the word is not issued. Instead it raises an error pulse.

Both sides use a valid/ready handshake. The result is registered, so a request accepted on one clock edge is presented at the output after that edge.

Lanes use big-endian numbering. Lane k occupies data bits `[31-8k -: 8]`, so lane 0 is the most significant byte. Enable bit `out_be[3-k]` belongs to lane k.

Top module: `wr_lane_mirror`

## Requirements
- R1: While reset is held and after it is released, `out_valid` and `out_err` are 0 and `in_ready` is 1.
- R2: The size code is 0 for one byte, 1 for two, 2 for three and 3 for four. For a legal request with offset o and size code s, `out_be[3-k]` is 1 exactly when o <= k <= o+s.
- R3: Every enabled lane carries the input byte of the same lane.
- R4: When lane 0 is not enabled, it carries a copy of the input byte at the lane selected by the offset.
- R5: When lane 1 is not enabled and offset bit 1 is set, lane 1 carries the input byte of lane 3 if lane 3 is enabled, and zero otherwise.
- R6: Lanes 2 and 3, when not enabled, are zero. Lane 1, when not enabled and offset bit 1 is clear, is also zero.
- R7: A request with o+s >= 4 is illegal. When it is accepted, `out_err` is 1 for the cycle after acceptance, and the request never produces `out_valid`.
- R8: `in_ready` equals `!out_valid || out_ready`. A legal request accepted at a clock edge is shown with `out_valid` high after that edge.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_be` and `out_data` keep their values into the next cycle.
- R10: A four-byte request at offset 0 enables all lanes and passes the data through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Stage can take a request this cycle |
| in_offset | input | 2 | Starting byte lane of the request |
| in_size | input | 2 | Transfer size code (bytes minus one) |
| in_data | input | 32 | Write data in natural lanes |
| out_valid | output | 1 | Steered beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_be | output | 4 | Byte enables, bit 3 = lane 0 |
| out_data | output | 32 | Lane-steered write data |
| out_err | output | 1 | One-cycle pulse for an accepted illegal request |

## Verification
Several properties are checked on every cycle: an output beat holds while it is stalled, no request is taken while the stage is full, and an error pulse follows only an accepted request whose offset plus size reaches four. Every beat also has at least one enable, lanes 2 and 3 are zero whenever they are disabled, and the single byte at the top offset is copied into lanes 0 and 1. Only the bench scenarios can show that each of the ten legal offset/size pairs produces exactly its enable pattern and mirrored word. The same applies to showing that illegal requests never reach the output, and that the stage keeps full throughput when downstream is always ready.

// File: rtl/wlm_pkg.sv
package wlm_pkg;

    // The lane count is fixed by the mirroring rules, which are defined for a four-lane word.
    localparam int LANES = 4;
    localparam int OFF_W = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_ONE   = 2'd0,
        SZ_TWO   = 2'd1,
        SZ_THREE = 2'd2,
        SZ_FOUR  = 2'd3
    } xfer_size_e;

endpackage

// File: rtl/wlm_decode.sv
module wlm_decode
    import wlm_pkg::*;
(
    input  logic [OFF_W-1:0] offset,
    input  logic [1:0]       size,
    output logic [LANES-1:0] be,
    output logic             legal
);

    xfer_size_e size_e;
    int         last_lane;

    always_comb begin
        size_e    = xfer_size_e'(size);
        last_lane = int'(offset) + int'(size_e);
        legal     = (last_lane < LANES);
    end

    // Enable bit LANES-1-k belongs to lane k (big-endian lane order).
    for (genvar k = 0; k < LANES; k++) begin : g_be
        assign be[LANES-1-k] = legal && (k >= int'(offset)) && (k <= last_lane);
    end

endmodule

// File: rtl/wlm_steer.sv
module wlm_steer
    import wlm_pkg::*;
#(
    parameter int LANE_W = 8,
    localparam int DW    = LANES * LANE_W
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [LANES-1:0] be,
    input  logic [DW-1:0]    data_in,
    output logic [DW-1:0]    data_out
);

    logic [LANE_W-1:0] lane_in  [LANES];
    logic [LANE_W-1:0] lane_out [LANES];
    logic [LANES-1:0]  lane_en;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_in[k] = data_in[(LANES-k)*LANE_W-1 -: LANE_W];
        assign lane_en[k] = be[LANES-1-k];
        assign data_out[(LANES-k)*LANE_W-1 -: LANE_W] = lane_out[k];
    end

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            lane_out[k] = lane_en[k] ? lane_in[k] : '0;
        end
        // A half-width target samples lanes 0..1: copy the upper half down.
        if (!lane_en[1] && offset[1]) begin
            lane_out[1] = lane_en[3] ? lane_in[3] : '0;
        end
        // A byte-wide target samples lane 0: give it the first addressed byte.
        if (!lane_en[0]) begin
            lane_out[0] = lane_in[offset];
        end
    end

endmodule

// File: rtl/wlm_stage.sv
module wlm_stage
    import wlm_pkg::*;
#(
    parameter int LANE_W = 8,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             legal,
    input  logic [LANES-1:0] be,
    input  logic [DW-1:0]    data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [LANES-1:0] out_be,
    output logic [DW-1:0]    out_data,
    output logic             out_err
);

    typedef struct packed {
        logic             valid;
        logic             err;
        logic [LANES-1:0] be;
        logic [DW-1:0]    data;
    } stage_t;

    stage_t st_d, st_q;
    logic   take_d;

    always_comb begin
        in_ready = !st_q.valid || out_ready;
        take_d   = in_valid && in_ready;
        st_d     = st_q;
        st_d.err = take_d && !legal;
        if (st_q.valid && out_ready) begin
            st_d.valid = 1'b0;
        end
        if (take_d && legal) begin
            st_d.valid = 1'b1;
            st_d.be    = be;
            st_d.data  = data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_be    = st_q.be;
    assign out_data  = st_q.data;
    assign out_err   = st_q.err;

endmodule

// File: rtl/wr_lane_mirror.sv
module wr_lane_mirror
    import wlm_pkg::*;
#(
    parameter int LANE_W = 8,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [OFF_W-1:0] in_offset,
    input  logic [1:0]       in_size,
    input  logic [DW-1:0]    in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [LANES-1:0] out_be,
    output logic [DW-1:0]    out_data,
    output logic             out_err
);

    logic [LANES-1:0] be_c;
    logic             legal_c;
    logic [DW-1:0]    steered_c;

    wlm_decode u_decode (
        .offset (in_offset),
        .size   (in_size),
        .be     (be_c),
        .legal  (legal_c)
    );

    wlm_steer #(.LANE_W(LANE_W)) u_steer (
        .offset   (in_offset),
        .be       (be_c),
        .data_in  (in_data),
        .data_out (steered_c)
    );

    wlm_stage #(.LANE_W(LANE_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .legal     (legal_c),
        .be        (be_c),
        .data      (steered_c),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_be    (out_be),
        .out_data  (out_data),
        .out_err   (out_err)
    );

endmodule

// File: rtl/wr_lane_mirror_chk.sv
module wr_lane_mirror_chk #(
    parameter int LANE_W = 8,
    localparam int DW    = 4 * LANE_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic [1:0]    in_offset,
    input logic [1:0]    in_size,
    input logic          out_valid,
    input logic          out_ready,
    input logic [3:0]    out_be,
    input logic [DW-1:0] out_data,
    input logic          out_err
);

    logic [LANE_W-1:0] ln0, ln1, ln2, ln3;
    assign ln0 = out_data[4*LANE_W-1 -: LANE_W];
    assign ln1 = out_data[3*LANE_W-1 -: LANE_W];
    assign ln2 = out_data[2*LANE_W-1 -: LANE_W];
    assign ln3 = out_data[LANE_W-1 -: LANE_W];

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_be) && $stable(out_data)));

    assert_full_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    assert_beat_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready));

    assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> ($past(in_valid && in_ready) &&
                     (({1'b0, $past(in_offset)} + {1'b0, $past(in_size)}) >= 3'd4)));

    assert_be_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_be) >= 1));

    assert_idle_lanes_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_be[1] || ln2 == '0) && (out_be[0] || ln3 == '0)));

    assert_top_byte_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_be == 4'b0001) |-> (ln0 == ln3 && ln1 == ln3));

endmodule

bind wr_lane_mirror wr_lane_mirror_chk #(.LANE_W(LANE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_offset (in_offset),
    .in_size   (in_size),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_be    (out_be),
    .out_data  (out_data),
    .out_err   (out_err)
);

// File: tb/wr_lane_mirror_test.sv
`timescale 1ns/1ps
module wr_lane_mirror_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_offset = '0;
    logic [1:0]  in_size = '0;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [3:0]  out_be;
    logic [31:0] out_data;
    logic        out_err;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    // bench model of the output registers
    logic        m_valid = 1'b0;
    logic        m_err   = 1'b0;
    logic [3:0]  m_be    = '0;
    logic [31:0] m_data  = '0;
    logic        prev_stall = 1'b0;
    logic [3:0]  prev_be   = '0;
    logic [31:0] prev_data = '0;

    always #2.5 clk = ~clk;

    wr_lane_mirror uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_offset(in_offset), .in_size(in_size), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_be(out_be), .out_data(out_data), .out_err(out_err)
    );

    function automatic bit exp_legal(input logic [1:0] off, input logic [1:0] sz);
        return (int'(off) + int'(sz)) < 4;
    endfunction

    function automatic logic [3:0] exp_be(input logic [1:0] off, input logic [1:0] sz);
        case ({sz, off})
            4'b00_00: return 4'b1000;
            4'b00_01: return 4'b0100;
            4'b00_10: return 4'b0010;
            4'b00_11: return 4'b0001;
            4'b01_00: return 4'b1100;
            4'b01_01: return 4'b0110;
            4'b01_10: return 4'b0011;
            4'b10_00: return 4'b1110;
            4'b10_01: return 4'b0111;
            4'b11_00: return 4'b1111;
            default:  return 4'b0000;
        endcase
    endfunction

    function automatic logic [31:0] exp_word(input logic [1:0] off, input logic [1:0] sz,
                                             input logic [31:0] d);
        logic [7:0] b0, b1, b2, b3;
        b0 = d[31:24]; b1 = d[23:16]; b2 = d[15:8]; b3 = d[7:0];
        case ({sz, off})
            4'b00_00: return {b0, 8'h00, 8'h00, 8'h00};
            4'b00_01: return {b1, b1, 8'h00, 8'h00};
            4'b00_10: return {b2, 8'h00, b2, 8'h00};
            4'b00_11: return {b3, b3, 8'h00, b3};
            4'b01_00: return {b0, b1, 8'h00, 8'h00};
            4'b01_01: return {b1, b1, b2, 8'h00};
            4'b01_10: return {b2, b3, b2, b3};
            4'b10_00: return {b0, b1, b2, 8'h00};
            4'b10_01: return {b1, b1, b2, b3};
            4'b11_00: return d;
            default:  return 32'h0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock cycle: compare outputs to the model, drive inputs, advance the model.
    task automatic step(input bit v, input logic [1:0] off, input logic [1:0] sz,
                        input logic [31:0] d, input bit rdy);
        bit acc, lg;
        @(negedge clk);
        check(out_valid == m_valid, "R8 out_valid", 32'(out_valid), 32'(m_valid));
        check(out_err == m_err, "R7 out_err", 32'(out_err), 32'(m_err));
        if (m_valid) begin
            check(out_be == m_be, "R2 out_be", 32'(out_be), 32'(m_be));
            check(out_data == m_data, "R3 R4 R5 R6 R10 out_data", out_data, m_data);
        end
        if (prev_stall) begin
            check(out_valid && out_be == prev_be && out_data == prev_data,
                  "R9 stall hold", out_data, prev_data);
        end
        in_valid  = v;
        in_offset = off;
        in_size   = sz;
        in_data   = d;
        out_ready = rdy;
        #0.5;
        check(in_ready == (!m_valid || rdy), "R8 in_ready", 32'(in_ready),
              32'(!m_valid || rdy));
        acc = v && (!m_valid || rdy);
        lg  = exp_legal(off, sz);
        prev_stall = m_valid && !rdy;
        prev_be    = out_be;
        prev_data  = out_data;
        @(posedge clk);
        m_err = acc && !lg;
        if (m_valid && rdy) m_valid = 1'b0;
        if (acc && lg) begin
            m_valid = 1'b1;
            m_be    = exp_be(off, sz);
            m_data  = exp_word(off, sz, d);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state while reset is held
        check(!out_valid && !out_err, "R1 reset outputs", {out_valid, out_err}, 0);
        check(in_ready == 1'b1, "R1 reset in_ready", 32'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !out_err, "R1 after release", {out_valid, out_err}, 0);

        // Directed: every offset/size pair, downstream always ready (R2..R7, R10)
        for (int s = 0; s < 4; s++) begin
            for (int o = 0; o < 4; o++) begin
                step(1'b1, 2'(o), 2'(s), 32'hA1B2C3D4, 1'b1);
            end
        end
        step(1'b0, 2'd0, 2'd0, 32'h0, 1'b1);

        // Directed stall: beat held, competing request refused (R8, R9)
        step(1'b1, 2'd3, 2'd0, 32'h11223344, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b1, 2'd2, 2'd1, 32'h55667788, 1'b0);
        step(1'b1, 2'd2, 2'd1, 32'h55667788, 1'b1);
        step(1'b0, 2'd0, 2'd0, 32'h0, 1'b1);

        // Illegal requests back to back, then a full word (R7, R10)
        step(1'b1, 2'd3, 2'd1, 32'hDEADBEEF, 1'b1);
        step(1'b1, 2'd1, 2'd3, 32'hDEADBEEF, 1'b1);
        step(1'b1, 2'd0, 2'd3, 32'hCAFEF00D, 1'b1);
        step(1'b0, 2'd0, 2'd0, 32'h0, 1'b1);

        // Constrained random traffic with random backpressure
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 4) != 0, 2'($urandom % 4), 2'($urandom % 4), $urandom,
                 ($urandom % 10) < 7);
        end
        step(1'b0, 2'd0, 2'd0, 32'h0, 1'b1);
        step(1'b0, 2'd0, 2'd0, 32'h0, 1'b1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule